// File: doc/BRIEF.md
# Seven-Stage Pipeline Hazard Controller

This block makes the hazard decisions for an in-order, single-issue pipeline of seven stages: two fetch stages, decode, execute, two data-memory stages and write-back. Each cycle it looks at the valid bit, operation code and register fields held in the pipeline latches. From these it produces, with no added latency, three kinds of control. The first is a bypass select for each execute-stage operand. The second is a freeze of the three front stages, paired with a bubble into execute, when a load result cannot reach its consumer in time. The third is a kill of every younger stage, with a fetch redirect, when a branch resolves taken.

Add and nor results exist at the end of execute and can be bypassed from any later latch. Load data exists only at the end of the second memory stage. A consumer in decode therefore waits two cycles behind a load in execute and one cycle behind a load in the first memory stage. Branches are predicted not taken and resolve in the second memory stage, so a taken branch discards five younger instructions.

Top module: `hz7_ctrl`

## Requirements
- R1: Operation codes are add=0, nor=1, lw=2, sw=3, beq=4, halt=6. Only add, nor and lw count as register producers; sw and beq never cause a bypass or a stall.
- R2: The bypass select of each execute operand is 0 for the register file, 1 for the EX/MEM1 latch, 2 for the MEM1/MEM2 latch and 3 for the MEM2/WB latch. It is 1, 2 or 3 when a valid producer in that latch writes the register the operand names.
- R3: When several latches match, the youngest wins: EX/MEM1 over MEM1/MEM2 over MEM2/WB.
- R4: A valid decode-stage instruction that reads the destination of a valid lw in execute raises the front freeze and the execute bubble. In a running pipeline this lasts exactly 2 cycles.
- R5: A decode-stage read of the destination of a valid lw in the first memory stage freezes for 1 cycle.
- R6: A lw in the second memory stage or in write-back causes no freeze. A lw in the MEM2/WB latch is bypassed with select 3.
- R7: Decode-stage reads are: add, nor, sw and beq read both source fields; lw reads only the first; halt reads none.
- R8: A valid beq in the second memory stage with the taken input high drives all five kill bits (fetch 1, fetch 2, decode, execute, memory 1) and the redirect. Only the taken target and the instructions after it then reach write-back.
- R9: A kill and a freeze requested in the same cycle give the kill only; the freeze and bubble stay low.
- R10: A destination or source of register 0, or an invalid latch, never produces a bypass or a freeze, and an invalid execute stage has both selects at 0.
- R11: An untaken beq, or the taken input high for any other operation, produces no kill and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the checking logic |
| rst | input | 1 | Synchronous active-high reset |
| id_vld | input | 1 | Decode stage holds an instruction |
| id_op | input | 3 | Decode-stage operation code |
| id_ra | input | RW | Decode-stage first source register |
| id_rb | input | RW | Decode-stage second source register |
| ex_vld | input | 1 | Execute stage holds an instruction |
| ex_op | input | 3 | Execute-stage operation code |
| ex_dst | input | RW | Execute-stage destination register |
| ex_ra | input | RW | Execute-stage first source register |
| ex_rb | input | RW | Execute-stage second source register |
| m1_vld | input | 1 | First memory stage holds an instruction |
| m1_op | input | 3 | First memory stage operation code |
| m1_dst | input | RW | First memory stage destination register |
| m2_vld | input | 1 | Second memory stage holds an instruction |
| m2_op | input | 3 | Second memory stage operation code |
| m2_dst | input | RW | Second memory stage destination register |
| m2_taken | input | 1 | Branch comparison result in the second memory stage |
| wb_vld | input | 1 | Write-back stage holds an instruction |
| wb_op | input | 3 | Write-back operation code |
| wb_dst | input | RW | Write-back destination register |
| fwd_a | output | 2 | Bypass select, first execute operand |
| fwd_b | output | 2 | Bypass select, second execute operand |
| hold_front | output | 1 | Freeze fetch 1, fetch 2 and decode latches |
| bubble_ex | output | 1 | Load a bubble into execute |
| kill | output | 5 | Kill bits, bit 0 fetch 1 up to bit 4 memory 1 |
| redirect | output | 1 | Load the fetch address with the branch target |

## Verification
The assertions assume that the surrounding pipeline obeys the block. After a freeze, execute holds a bubble. After a kill, the second memory stage is empty. No lw is ever waiting in the first or second memory stage while its consumer sits in execute. The vector table keeps to these rules by following every applied vector with an all-idle cycle and by never placing a load ahead of an execute-stage reader. The behavioural pipeline in the bench keeps to them because it freezes, bubbles and kills exactly as the outputs command.

// File: rtl/hz7_pkg.sv
package hz7_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_NOR  = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_RSV5 = 3'd5,
    OP_HALT = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    FW_RF = 2'd0,
    FW_M1 = 2'd1,
    FW_M2 = 2'd2,
    FW_WB = 2'd3
  } fwd_e;

  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_NOR) || (op == OP_LW);
  endfunction

  function automatic logic op_reads_a(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_NOR) || (op == OP_LW) ||
           (op == OP_SW) || (op == OP_BEQ);
  endfunction

  function automatic logic op_reads_b(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_NOR) || (op == OP_SW) || (op == OP_BEQ);
  endfunction
endpackage

// File: rtl/hz7_fwd_mux.sv
module hz7_fwd_mux
  import hz7_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            use_vld,
  input  logic [RW-1:0]   src,
  input  logic            m1_vld,
  input  logic [OP_W-1:0] m1_op,
  input  logic [RW-1:0]   m1_dst,
  input  logic            m2_vld,
  input  logic [OP_W-1:0] m2_op,
  input  logic [RW-1:0]   m2_dst,
  input  logic            wb_vld,
  input  logic [OP_W-1:0] wb_op,
  input  logic [RW-1:0]   wb_dst,
  output logic [1:0]      sel
);
  logic src_live, hit_m1, hit_m2, hit_wb;

  always_comb begin
    src_live = use_vld && (src != '0);
    hit_m1   = src_live && m1_vld && op_writes(m1_op) && (m1_dst == src);
    hit_m2   = src_live && m2_vld && op_writes(m2_op) && (m2_dst == src);
    hit_wb   = src_live && wb_vld && op_writes(wb_op) && (wb_dst == src);
    if (hit_m1)      sel = FW_M1;
    else if (hit_m2) sel = FW_M2;
    else if (hit_wb) sel = FW_WB;
    else             sel = FW_RF;
  end

  // A load must never be the selected source before its data exists (R6)
  assert_no_early_load_m1_R6: assert property (@(posedge clk) disable iff (rst)
    (sel == FW_M1) |-> (m1_op != OP_LW));
  assert_no_early_load_m2_R6: assert property (@(posedge clk) disable iff (rst)
    (sel == FW_M2) |-> (m2_op != OP_LW));
  // Register 0 is never bypassed (R10)
  assert_no_r0_bypass_R10: assert property (@(posedge clk) disable iff (rst)
    (sel != FW_RF) |-> (src != '0));
endmodule

// File: rtl/hz7_loaduse.sv
module hz7_loaduse
  import hz7_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            id_vld,
  input  logic [OP_W-1:0] id_op,
  input  logic [RW-1:0]   id_ra,
  input  logic [RW-1:0]   id_rb,
  input  logic            ex_vld,
  input  logic [OP_W-1:0] ex_op,
  input  logic [RW-1:0]   ex_dst,
  input  logic            m1_vld,
  input  logic [OP_W-1:0] m1_op,
  input  logic [RW-1:0]   m1_dst,
  input  logic            flush,
  output logic            hold,
  output logic            bubble
);
  function automatic logic needs(input logic [OP_W-1:0] op, input logic [RW-1:0] a,
                                 input logic [RW-1:0] b, input logic [RW-1:0] d);
    return (d != '0) && ((op_reads_a(op) && (a == d)) || (op_reads_b(op) && (b == d)));
  endfunction

  logic wait_ex, wait_m1, stall_req;

  always_comb begin
    wait_ex   = ex_vld && (ex_op == OP_LW) && needs(id_op, id_ra, id_rb, ex_dst);
    wait_m1   = m1_vld && (m1_op == OP_LW) && needs(id_op, id_ra, id_rb, m1_dst);
    stall_req = id_vld && (wait_ex || wait_m1);
    hold      = stall_req && !flush;
    bubble    = hold;
  end

  // The environment must follow a freeze with a bubble in execute (R4)
  assert_bubble_follows_R4: assert property (@(posedge clk) disable iff (rst)
    hold |=> !ex_vld);
endmodule

// File: rtl/hz7_flush.sv
module hz7_flush
  import hz7_pkg::*;
#(
  parameter int N_KILL = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            m2_vld,
  input  logic [OP_W-1:0] m2_op,
  input  logic            m2_taken,
  output logic [N_KILL-1:0] kill,
  output logic            redirect
);
  logic fire;

  always_comb fire = m2_vld && (m2_op == OP_BEQ) && m2_taken;
  assign redirect = fire;

  for (genvar s = 0; s < N_KILL; s++) begin : g_kill
    assign kill[s] = fire;
  end

  // After a kill the memory-1 slot was emptied, so memory 2 is empty next (R8)
  assert_flush_drains_R8: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !m2_vld);
endmodule

// File: rtl/hz7_ctrl.sv
module hz7_ctrl
  import hz7_pkg::*;
#(
  parameter int RW     = 3,
  parameter int N_KILL = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_vld,
  input  logic [2:0]        id_op,
  input  logic [RW-1:0]     id_ra,
  input  logic [RW-1:0]     id_rb,
  input  logic              ex_vld,
  input  logic [2:0]        ex_op,
  input  logic [RW-1:0]     ex_dst,
  input  logic [RW-1:0]     ex_ra,
  input  logic [RW-1:0]     ex_rb,
  input  logic              m1_vld,
  input  logic [2:0]        m1_op,
  input  logic [RW-1:0]     m1_dst,
  input  logic              m2_vld,
  input  logic [2:0]        m2_op,
  input  logic [RW-1:0]     m2_dst,
  input  logic              m2_taken,
  input  logic              wb_vld,
  input  logic [2:0]        wb_op,
  input  logic [RW-1:0]     wb_dst,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              hold_front,
  output logic              bubble_ex,
  output logic [N_KILL-1:0] kill,
  output logic              redirect
);
  localparam int N_OPND = 2;

  logic [RW-1:0] opnd [N_OPND];
  logic [1:0]    sel  [N_OPND];
  logic          flush;

  assign opnd[0] = ex_ra;
  assign opnd[1] = ex_rb;

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    hz7_fwd_mux #(.RW(RW)) u_mux (
      .clk(clk), .rst(rst), .use_vld(ex_vld), .src(opnd[k]),
      .m1_vld(m1_vld), .m1_op(m1_op), .m1_dst(m1_dst),
      .m2_vld(m2_vld), .m2_op(m2_op), .m2_dst(m2_dst),
      .wb_vld(wb_vld), .wb_op(wb_op), .wb_dst(wb_dst),
      .sel(sel[k])
    );
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  hz7_flush #(.N_KILL(N_KILL)) u_flush (
    .clk(clk), .rst(rst), .m2_vld(m2_vld), .m2_op(m2_op), .m2_taken(m2_taken),
    .kill(kill), .redirect(flush)
  );
  assign redirect = flush;

  hz7_loaduse #(.RW(RW)) u_lu (
    .clk(clk), .rst(rst),
    .id_vld(id_vld), .id_op(id_op), .id_ra(id_ra), .id_rb(id_rb),
    .ex_vld(ex_vld), .ex_op(ex_op), .ex_dst(ex_dst),
    .m1_vld(m1_vld), .m1_op(m1_op), .m1_dst(m1_dst),
    .flush(flush), .hold(hold_front), .bubble(bubble_ex)
  );

  // Kill bits go together (R8)
  assert_kill_all_or_none_R8: assert property (@(posedge clk) disable iff (rst)
    ($countones(kill) == 0) || ($countones(kill) == N_KILL));
  // A kill overrides a freeze (R9)
  assert_flush_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (kill != '0) |-> (!hold_front && !bubble_ex));
endmodule

// File: tb/sim_hz7_ctrl.sv
`timescale 1ns/1ps
module sim_hz7_ctrl;
  localparam int RW = 3;
  localparam int NK = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          id_vld, ex_vld, m1_vld, m2_vld, wb_vld, m2_taken;
  logic [2:0]    id_op, ex_op, m1_op, m2_op, wb_op;
  logic [RW-1:0] id_ra, id_rb, ex_dst, ex_ra, ex_rb, m1_dst, m2_dst, wb_dst;
  logic [1:0]    fwd_a, fwd_b;
  logic          hold_front, bubble_ex, redirect;
  logic [NK-1:0] kill;

  hz7_ctrl #(.RW(RW), .N_KILL(NK)) u0 (.*);

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [3:0] req;
    logic iv; logic [2:0] iop, ia, ib;
    logic ev; logic [2:0] eop, ed, ea, eb;
    logic mv; logic [2:0] mop, md;
    logic nv; logic [2:0] nop, nd; logic ntk;
    logic wv; logic [2:0] wop, wd;
    logic [1:0] xa, xb; logic xh, xk;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    // R10 idle
    '{4'd10, 1'b0,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R2 add in EX/MEM1
    '{4'd2, 1'b0,3'd0,3'd0,3'd0, 1'b1,3'd0,3'd7,3'd1,3'd2, 1'b1,3'd0,3'd1, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd1,2'd0,1'b0,1'b0},
    // R2 nor in MEM1/MEM2
    '{4'd2, 1'b0,3'd0,3'd0,3'd0, 1'b1,3'd1,3'd7,3'd3,3'd4, 1'b0,3'd0,3'd0, 1'b1,3'd1,3'd4,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd2,1'b0,1'b0},
    // R6 lw in MEM2/WB bypassed with select 3
    '{4'd6, 1'b0,3'd0,3'd0,3'd0, 1'b1,3'd0,3'd7,3'd5,3'd5, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,1'b0, 1'b1,3'd2,3'd5, 2'd3,2'd3,1'b0,1'b0},
    // R3 three matches, youngest wins
    '{4'd3, 1'b0,3'd0,3'd0,3'd0, 1'b1,3'd0,3'd7,3'd1,3'd1, 1'b1,3'd0,3'd1, 1'b1,3'd0,3'd1,1'b0, 1'b1,3'd2,3'd1, 2'd1,2'd1,1'b0,1'b0},
    // R3 MEM1/MEM2 over MEM2/WB
    '{4'd3, 1'b0,3'd0,3'd0,3'd0, 1'b1,3'd0,3'd7,3'd2,3'd3, 1'b0,3'd0,3'd0, 1'b1,3'd1,3'd2,1'b0, 1'b1,3'd0,3'd2, 2'd2,2'd0,1'b0,1'b0},
    // R10 register 0 not bypassed
    '{4'd10, 1'b0,3'd0,3'd0,3'd0, 1'b1,3'd0,3'd7,3'd0,3'd0, 1'b1,3'd0,3'd0, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R10 invalid producer ignored
    '{4'd10, 1'b0,3'd0,3'd0,3'd0, 1'b1,3'd0,3'd7,3'd1,3'd1, 1'b0,3'd0,3'd1, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R1 sw and beq are not producers
    '{4'd1, 1'b0,3'd0,3'd0,3'd0, 1'b1,3'd0,3'd7,3'd1,3'd2, 1'b1,3'd3,3'd1, 1'b1,3'd4,3'd2,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R4 lw in EX, reader in ID
    '{4'd4, 1'b1,3'd0,3'd1,3'd2, 1'b1,3'd2,3'd2,3'd3,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b1,1'b0},
    // R5 lw in MEM1, sw reads it
    '{4'd5, 1'b1,3'd3,3'd3,3'd4, 1'b0,3'd0,3'd0,3'd0,3'd0, 1'b1,3'd2,3'd4, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b1,1'b0},
    // R7 lw in ID does not read its second field
    '{4'd7, 1'b1,3'd2,3'd5,3'd1, 1'b1,3'd2,3'd1,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R7 halt reads nothing
    '{4'd7, 1'b1,3'd6,3'd1,3'd1, 1'b1,3'd2,3'd1,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R6 lw in MEM2 needs no freeze
    '{4'd6, 1'b1,3'd0,3'd1,3'd2, 1'b0,3'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b1,3'd2,3'd1,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R10 lw to register 0
    '{4'd10, 1'b1,3'd0,3'd0,3'd0, 1'b1,3'd2,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R10 invalid ID
    '{4'd10, 1'b0,3'd0,3'd1,3'd1, 1'b1,3'd2,3'd1,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R8 taken beq
    '{4'd8, 1'b0,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b1,3'd4,3'd0,1'b1, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b1},
    // R11 untaken beq
    '{4'd11, 1'b0,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b1,3'd4,3'd0,1'b0, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R11 taken input on sw
    '{4'd11, 1'b0,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b1,3'd3,3'd0,1'b1, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b0},
    // R9 freeze and kill together
    '{4'd9, 1'b1,3'd0,3'd1,3'd2, 1'b1,3'd2,3'd1,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b1,3'd4,3'd0,1'b1, 1'b0,3'd0,3'd0, 2'd0,2'd0,1'b0,1'b1}
  };

  task automatic drive_vec(input vec_t v);
    id_vld = v.iv; id_op = v.iop; id_ra = v.ia; id_rb = v.ib;
    ex_vld = v.ev; ex_op = v.eop; ex_dst = v.ed; ex_ra = v.ea; ex_rb = v.eb;
    m1_vld = v.mv; m1_op = v.mop; m1_dst = v.md;
    m2_vld = v.nv; m2_op = v.nop; m2_dst = v.nd; m2_taken = v.ntk;
    wb_vld = v.wv; wb_op = v.wop; wb_dst = v.wd;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural pipeline: 0 IF1, 1 IF2, 2 ID, 3 EX, 4 MEM1, 5 MEM2, 6 WB
  typedef struct packed {
    logic v; logic [2:0] op, d, a, b; logic tk; logic [3:0] tgt;
  } ins_t;

  ins_t st [7];
  ins_t prog [8];
  int   plen;
  int   n_hold, n_kill, n_ret, n_ret_d1;
  logic [1:0] mk_a, mk_b;

  function automatic ins_t mk(input logic [2:0] op, input logic [2:0] d,
                              input logic [2:0] a, input logic [2:0] b,
                              input logic tk, input logic [3:0] tgt);
    mk = '{1'b1, op, d, a, b, tk, tgt};
  endfunction

  task automatic run_prog(input int ncyc, input logic [2:0] mark_d);
    int pc = 0;
    for (int i = 0; i < 7; i++) st[i] = '0;
    n_hold = 0; n_kill = 0; n_ret = 0; n_ret_d1 = 0; mk_a = 2'bxx; mk_b = 2'bxx;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      id_vld = st[2].v; id_op = st[2].op; id_ra = st[2].a; id_rb = st[2].b;
      ex_vld = st[3].v; ex_op = st[3].op; ex_dst = st[3].d; ex_ra = st[3].a; ex_rb = st[3].b;
      m1_vld = st[4].v; m1_op = st[4].op; m1_dst = st[4].d;
      m2_vld = st[5].v; m2_op = st[5].op; m2_dst = st[5].d; m2_taken = st[5].tk;
      wb_vld = st[6].v; wb_op = st[6].op; wb_dst = st[6].d;
      #1;
      if (st[3].v && st[3].op == 3'd0 && st[3].d == mark_d) begin
        mk_a = fwd_a; mk_b = fwd_b;
      end
      if (st[6].v) n_ret++;
      if (st[6].v && st[6].op == 3'd0 && st[6].d == 3'd1) n_ret_d1++;
      if (hold_front) n_hold++;
      if (redirect) n_kill++;
      st[6] = st[5];
      if (redirect) begin
        pc = int'(st[5].tgt);
        for (int i = 1; i < 6; i++) st[i] = '0;
        st[0] = (pc < plen) ? prog[pc] : '0;
        pc++;
      end else if (hold_front) begin
        st[5] = st[4]; st[4] = st[3]; st[3] = '0;
      end else begin
        for (int i = 5; i > 0; i--) st[i] = st[i-1];
        st[0] = (pc < plen) ? prog[pc] : '0;
        pc++;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drive_vec('0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R10 all-idle inputs during reset give quiet outputs
    check("R10 reset", {8'd0, fwd_a, fwd_b, hold_front, bubble_ex, kill[0], redirect},
          16'd0);
    rst = 1'b0;

    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      drive_vec(VEC[n]);
      #1;
      check($sformatf("R%0d vector %0d", VEC[n].req, n),
            {6'd0, fwd_a, fwd_b, hold_front, bubble_ex, kill, redirect},
            {6'd0, VEC[n].xa, VEC[n].xb, VEC[n].xh, VEC[n].xh,
             {NK{VEC[n].xk}}, VEC[n].xk});
      @(negedge clk);
      drive_vec('0);
    end

    // R4: lw r1 then add r2 = r1,r1 -> two-cycle freeze, bypass from WB latch
    plen = 3;
    prog[0] = mk(3'd2, 3'd1, 3'd0, 3'd0, 1'b0, 4'd0);
    prog[1] = mk(3'd0, 3'd2, 3'd1, 3'd1, 1'b0, 4'd0);
    prog[2] = mk(3'd6, 3'd0, 3'd0, 3'd0, 1'b0, 4'd0);
    run_prog(20, 3'd2);
    check("R4 freeze cycles", 16'(n_hold), 16'd2);
    check("R6 bypass after lw stall", {12'd0, mk_a, mk_b}, {12'd0, 2'd3, 2'd3});
    check("R4 retired", 16'(n_ret), 16'd3);

    // R5: lw r1, independent nor, add r2 = r1,r0 -> one-cycle freeze
    prog[0] = mk(3'd2, 3'd1, 3'd0, 3'd0, 1'b0, 4'd0);
    prog[1] = mk(3'd1, 3'd3, 3'd4, 3'd5, 1'b0, 4'd0);
    prog[2] = mk(3'd0, 3'd2, 3'd1, 3'd0, 1'b0, 4'd0);
    run_prog(20, 3'd2);
    check("R5 freeze cycles", 16'(n_hold), 16'd1);
    check("R5 bypass selects", {12'd0, mk_a, mk_b}, {12'd0, 2'd3, 2'd0});

    // R2: add r1 then add r2 = r1,r1 -> no freeze, bypass from EX/MEM1
    prog[0] = mk(3'd0, 3'd1, 3'd4, 3'd5, 1'b0, 4'd0);
    prog[1] = mk(3'd0, 3'd2, 3'd1, 3'd1, 1'b0, 4'd0);
    prog[2] = mk(3'd6, 3'd0, 3'd0, 3'd0, 1'b0, 4'd0);
    run_prog(20, 3'd2);
    check("R2 no freeze for add chain", 16'(n_hold), 16'd0);
    check("R2 adjacent bypass", {12'd0, mk_a, mk_b}, {12'd0, 2'd1, 2'd1});

    // R8: taken beq to entry 4; entries 1..3 squashed
    plen = 6;
    prog[0] = mk(3'd4, 3'd0, 3'd0, 3'd0, 1'b1, 4'd4);
    prog[1] = mk(3'd0, 3'd1, 3'd0, 3'd0, 1'b0, 4'd0);
    prog[2] = mk(3'd0, 3'd5, 3'd0, 3'd0, 1'b0, 4'd0);
    prog[3] = mk(3'd0, 3'd6, 3'd0, 3'd0, 1'b0, 4'd0);
    prog[4] = mk(3'd0, 3'd2, 3'd0, 3'd0, 1'b0, 4'd0);
    prog[5] = mk(3'd6, 3'd0, 3'd0, 3'd0, 1'b0, 4'd0);
    run_prog(24, 3'd2);
    check("R8 one redirect", 16'(n_kill), 16'd1);
    check("R8 retired after flush", 16'(n_ret), 16'd3);
    check("R8 squashed add never retires", 16'(n_ret_d1), 16'd0);
    check("R10 target reads r0", {12'd0, mk_a, mk_b}, 16'd0);

    @(negedge clk);
    drive_vec('0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule